// File: doc/BRIEF.md
# Framed Serial DAC Input Interface

This block is the digital front end of a 12-bit serial-input converter. A host opens a frame by pulling an active-low frame select, then presents serial data bits that are captured on falling edges of a serial clock. An internal bit counter admits exactly sixteen bits per frame. After the sixteenth bit it closes, so the host may use either a burst of sixteen clock pulses or a free-running clock.

The sixteen-bit word starts with four bits that carry no meaning. The 12-bit code follows, most significant bit first. A falling edge on an active-low load input copies the low twelve bits of the shift register into the DAC latch. If the load input is held low through the frame, the latch updates by itself on the sixteenth accepted edge. Only the latch drives the converter code.

All four serial-side inputs are brought into the system clock domain through two-flop synchronizers. Their edges are detected there, so the serial clock must run several times slower than the system clock. Each latch write raises a one-cycle update strobe.

Top module: `serial_dac_frontend`

## Requirements
- R1: After synchronous active-low reset the latch output is zero, the update strobe is low, and the bit gate is closed: serial clock falls that arrive before any frame opens shift nothing in.
- R2: While a frame is open, each falling serial clock edge shifts the data bit into the shift register, most significant bit first. The code is the last twelve of the sixteen bits, and the first four bits never reach the latch.
- R3: Each frame accepts exactly sixteen falling edges. Later falling edges in the same frame leave the shift register unchanged.
- R4: A falling edge on the frame select clears the bit counter and opens the gate. The shift register keeps its contents.
- R5: A falling edge on the load input copies the low twelve bits of the shift register into the latch.
- R6: Shifting alone never changes the latch while the load input stays high.
- R7: When the load input is low at the sixteenth accepted edge, the latch takes the completed code automatically.
- R8: If the frame select returns high before sixteen bits arrive, the latch is unchanged. The next frame then starts counting from zero.
- R9: A load falling edge in the middle of a frame copies whatever the low twelve bits of the shift register hold at that moment.
- R10: Every latch write raises the update strobe for one system clock cycle. The latch never changes without the strobe.
- R11: Falling serial clock edges while the frame select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_data_i | input | 1 | Serial data bit |
| frame_n_i | input | 1 | Active-low frame select |
| load_n_i | input | 1 | Active-low load; a falling edge loads the latch, holding it low selects auto-update |
| dac_code_o | output | 12 | Registered DAC latch value |
| dac_update_o | output | 1 | One-cycle strobe on each latch write |

## Verification
A table of frames is driven through the interface. The frames vary the four leading bits, the code values (all zeros, all ones, single end bits, mixed patterns) and the number of surplus clock edges after the sixteenth bit. This separates bit-order and field-position errors from counting errors, because surplus ones would shift a visible pattern into the latch if the gate failed to close. Each frame is loaded either with a load pulse or in auto-update mode, which shows that both write paths take the same code. Directed tests then cover aborted frames, clock edges outside a frame, and a mid-frame load, whose expected partial code is worked out from the earlier word and the bits sent so far.

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
  parameter int FRAME_BITS  = 16,
  parameter int CODE_BITS   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk_i,
  input  logic                 ser_data_i,
  input  logic                 frame_n_i,
  input  logic                 load_n_i,
  output logic [CODE_BITS-1:0] dac_code_o,
  output logic                 dac_update_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] FULL  = CW'(FRAME_BITS);
  localparam logic [CW-1:0] LASTI = CW'(FRAME_BITS - 1);

  logic [3:0] stg [SYNC_STAGES+1];
  logic [3:0] cur, prv;
  logic [CW-1:0] bit_cnt;
  logic [FRAME_BITS-1:0] shreg, shreg_nxt;
  logic clk_fall, frame_lo, frame_fall, load_lo, load_fall;
  logic shift_en, last_bit, write_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= SYNC_STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= {load_n_i, frame_n_i, ser_data_i, ser_clk_i};
      for (int i = 1; i <= SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign cur        = stg[SYNC_STAGES-1];
  assign prv        = stg[SYNC_STAGES];
  assign clk_fall   = prv[0] & ~cur[0];
  assign frame_lo   = ~cur[2];
  assign frame_fall = prv[2] & ~cur[2];
  assign load_lo    = ~cur[3];
  assign load_fall  = prv[3] & ~cur[3];

  assign shift_en  = frame_lo && !frame_fall && clk_fall && (bit_cnt != FULL);
  assign last_bit  = shift_en && (bit_cnt == LASTI);
  assign shreg_nxt = shift_en ? {shreg[FRAME_BITS-2:0], cur[1]} : shreg;
  assign write_en  = load_fall || (last_bit && load_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt      <= FULL;
      shreg        <= '0;
      dac_code_o   <= '0;
      dac_update_o <= 1'b0;
    end else begin
      if (frame_fall)    bit_cnt <= '0;
      else if (shift_en) bit_cnt <= bit_cnt + 1'b1;
      shreg        <= shreg_nxt;
      dac_update_o <= write_en;
      if (write_en) dac_code_o <= shreg_nxt[CODE_BITS-1:0];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (dac_code_o == '0 && !dac_update_o));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);

  p_gate_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == FULL && !frame_fall) |=> $stable(shreg));

  p_idle_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_lo |=> $stable(shreg));

  p_auto_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && load_lo) |=> dac_update_o);

  p_strobe_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> dac_update_o);
endmodule

// File: tb/serial_dac_frontend_test.sv
module serial_dac_frontend_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b1, ser_data = 1'b0, frame_n = 1'b1, load_n = 1'b1;
  logic [11:0] code;
  logic upd;
  int checks = 0, failures = 0, strobes = 0, doubles = 0;
  logic upd_prev = 1'b0;

  always #10 clk = ~clk;

  serial_dac_frontend uut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
    .frame_n_i(frame_n), .load_n_i(load_n), .dac_code_o(code), .dac_update_o(upd));

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) strobes++;
      if (upd && upd_prev) doubles++;
    end
    upd_prev = upd;
  end

  // word[19:4] frame, word[3] auto mode, word[2:0] surplus edges
  localparam logic [19:0] VEC [6] = '{
    {16'hA000, 1'b0, 3'd0},
    {16'h5FFF, 1'b0, 3'd3},
    {16'h0801, 1'b1, 3'd0},
    {16'hF123, 1'b0, 3'd7},
    {16'h3A5C, 1'b1, 3'd5},
    {16'hC7E1, 1'b0, 3'd1}
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sedge(logic b);
    ser_data = b; wcyc(4);
    ser_clk = 1'b0; wcyc(4);
    ser_clk = 1'b1; wcyc(4);
  endtask

  task automatic send(logic [15:0] w, int n);
    for (int i = 15; i > 15 - n; i--) sedge(w[i]);
  endtask

  task automatic ldpulse();
    load_n = 1'b0; wcyc(5);
    load_n = 1'b1; wcyc(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [11:0] prev;
    wcyc(4);
    rst_n = 1'b1; wcyc(2);
    chk("R1 code", 16'(code), 16'h000);
    chk("R1 strobe", 16'(upd), 16'h0);
    for (int i = 0; i < 3; i++) sedge(1'b1);
    ldpulse();
    chk("R1 gate closed", 16'(code), 16'h000);

    prev = 12'h000;
    for (int v = 0; v < 6; v++) begin
      logic [15:0] w = VEC[v][19:4];
      if (VEC[v][3]) begin
        load_n = 1'b0; wcyc(6);
      end
      strobes = 0;
      frame_n = 1'b0; wcyc(4);
      send(w, 16);
      for (int e = 0; e < int'(VEC[v][2:0]); e++) sedge(e[0] == 1'b0);
      if (VEC[v][3]) begin
        chk("R7 auto update", 16'(code), 16'(w[11:0]));
        frame_n = 1'b1; load_n = 1'b1; wcyc(5);
      end else begin
        chk("R6 latch held", 16'(code), 16'(prev));
        frame_n = 1'b1; wcyc(4);
        ldpulse();
        chk("R2 R3 R5 loaded code", 16'(code), 16'(w[11:0]));
      end
      chk("R10 one strobe", 16'(strobes), 16'd1);
      prev = w[11:0];
    end

    // Abort: 6 bits then frame high; latch unchanged (R8)
    strobes = 0;
    frame_n = 1'b0; wcyc(4);
    send(16'hFC00, 6);
    frame_n = 1'b1; wcyc(4);
    chk("R8 abort latch", 16'(code), 16'(prev));
    chk("R8 abort strobe", 16'(strobes), 16'd0);
    // edges with frame high ignored (R11): shreg low 12 = {prev[5:0],6'b111111}
    for (int i = 0; i < 4; i++) sedge(1'b0);
    ldpulse();
    chk("R11 idle edges ignored", 16'(code), 16'({prev[5:0], 6'h3F}));
    // next frame counts from zero (R4)
    frame_n = 1'b0; wcyc(4);
    send(16'h96B4, 16);
    sedge(1'b1);
    frame_n = 1'b1; wcyc(4);
    ldpulse();
    chk("R4 R8 fresh frame", 16'(code), 16'h6B4);

    // Mid-frame load (R9): after 8 bits of 8'h5A, low 12 = {4'h4, 8'h5A}
    frame_n = 1'b0; wcyc(4);
    send(16'h5A00, 8);
    strobes = 0;
    ldpulse();
    chk("R9 partial load", 16'(code), 16'h45A);
    chk("R9 strobe", 16'(strobes), 16'd1);
    frame_n = 1'b1; wcyc(4);
    chk("R10 no double strobe", 16'(doubles), 16'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule